// File: doc/BRIEF.md
# Ethernet DMA Interrupt and Control Register Block

This block is the software-visible register slice that sits in front of an Ethernet DMA engine. Through a 32-bit register port, software starts and stops the transmit and receive engines, kicks the transmit engine to look for a new descriptor, chooses which interrupt causes may reach the processor, and reads a status word. The status word holds latched per-cause event bits, two summary bits (normal and abnormal), and the live 3-bit process-state codes that the transmit and receive engines report.

Each cause is raised by a one-cycle pulse from the engine side and stays latched until software writes a 1 to its bit position. The summary bits are derived from the enabled causes. A single registered interrupt line goes to the interrupt controller. The block decodes four word addresses through a register-select enumeration with the values CTRL (0), POLL (1), IEN (2) and STAT (3). Each select value routes a write strobe and a read path. There are no transitions between them, because every access completes in one cycle.

Top module: `dma_irq_csr`

## Requirements
- R1: After reset, every register reads 0, `tx_run_o`, `rx_run_o`, `tx_poll_o` and `irq_o` are low, and all latched causes are clear.
- R2: The control word (address 0) holds a transmit-start bit at bit 0 and a receive-start bit at bit 1. Each bit reads back exactly as last written and drives `tx_run_o` and `rx_run_o` respectively. All other bits read 0.
- R3: Any write to address 1 drives `tx_poll_o` high for exactly the one cycle after the write edge. Address 1 reads as 0.
- R4: A pulse on `ev_i[k]` sets status bit k, and the bit stays set until it is cleared. The cause positions are: 0 transmit done, 1 transmit stopped, 2 transmit jabber, 3 receive overflow, 4 transmit underflow, 5 receive done, 6 receive buffer unavailable, 7 receive stopped, 8 receive watchdog, 9 early transmit, 10 fatal bus error.
- R5: A write to the status word (address 3) clears each cause bit written with 1 and leaves bits written with 0 unchanged. Writes to bits 17 and above have no effect.
- R6: If a cause event and a write-one-to-clear of the same bit occur in the same cycle, the bit ends up set.
- R7: Status bit 15 (abnormal summary) is 1 exactly when some cause other than 0 and 5 is both set and enabled.
- R8: Status bit 16 (normal summary) is 1 exactly when cause 0 or cause 5 is both set and enabled.
- R9: `irq_o` is registered. It equals, one cycle later, (bit 15 AND enable bit 15) OR (bit 16 AND enable bit 16).
- R10: The enable word (address 2) holds per-cause enables at bits 10..0 and summary enables at bits 15 and 16, and reads back as written. With the enable word at 0, causes still latch, but both summaries read 0 and `irq_o` stays low.
- R11: Status bits 22..20 show `tx_state_i` and bits 19..17 show `rx_state_i` in the same cycle. Transmit codes: 0 stopped, 1 fetching descriptor, 2 waiting for end of transmission, 3 reading data into the buffer, 6 suspended, 7 closing descriptor. Receive codes: 0 stopped, 1 fetching descriptor, 2 checking for end of packet, 3 waiting for a packet, 4 suspended, 5 closing descriptor, 6 flushing the frame, 7 queuing the frame into memory.
- R12: Writing 1 to a summary bit leaves it reading 1 while an enabled contributing cause is still set, and reading 0 when none is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_addr | input | ADDR_W | Word address of the register access |
| csr_wr | input | 1 | Write strobe, one access per cycle |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data for `csr_addr` (combinational) |
| ev_i | input | 11 | One-cycle cause event pulses, one bit per cause position |
| tx_state_i | input | 3 | Live transmit engine process state |
| rx_state_i | input | 3 | Live receive engine process state |
| tx_run_o | output | 1 | Transmit engine start bit |
| rx_run_o | output | 1 | Receive engine start bit |
| tx_poll_o | output | 1 | One-cycle transmit poll-demand strobe |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The cause latches are driven with an all-causes burst while every enable is off. This separates the latching of causes from the summary and interrupt gating. Single causes are then pulsed with only chosen enables set: an unenabled abnormal cause, followed by an enabled one, shows whether the abnormal summary respects the per-cause mask. A normal cause, followed by its clear, shows the one-cycle lag of the interrupt on both edges. Clear patterns with mixed ones and zeros, writes to reserved upper bits, and a clear that collides with an event on the same bit tell correct write-one-to-clear handling apart from a plain overwrite or from clear-wins priority.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

    localparam int CSR_W   = 32;
    localparam int N_CAUSE = 11;
    localparam int ST_W    = 3;

    // cause positions in the status and enable words
    localparam int C_TX_DONE   = 0;
    localparam int C_TX_STOP   = 1;
    localparam int C_TX_JABBER = 2;
    localparam int C_RX_OVF    = 3;
    localparam int C_TX_UNF    = 4;
    localparam int C_RX_DONE   = 5;
    localparam int C_RX_NOBUF  = 6;
    localparam int C_RX_STOP   = 7;
    localparam int C_RX_WDOG   = 8;
    localparam int C_TX_EARLY  = 9;
    localparam int C_BUS_FATAL = 10;

    localparam int AIS_BIT   = 15;
    localparam int NIS_BIT   = 16;
    localparam int RX_ST_LSB = 17;
    localparam int TX_ST_LSB = RX_ST_LSB + ST_W;

    localparam int CTRL_TX_BIT = 0;
    localparam int CTRL_RX_BIT = 1;

    localparam logic [N_CAUSE-1:0] NORM_MASK =
        N_CAUSE'((1 << C_TX_DONE) | (1 << C_RX_DONE));
    localparam logic [N_CAUSE-1:0] ABN_MASK = ~NORM_MASK;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_POLL = 2'd1,
        SEL_IEN  = 2'd2,
        SEL_STAT = 2'd3
    } csr_sel_e;

    typedef enum logic [ST_W-1:0] {
        TXS_STOPPED = 3'd0,
        TXS_FETCH   = 3'd1,
        TXS_WAIT    = 3'd2,
        TXS_READ    = 3'd3,
        TXS_SUSPEND = 3'd6,
        TXS_CLOSE   = 3'd7
    } tx_state_e;

    typedef enum logic [ST_W-1:0] {
        RXS_STOPPED = 3'd0,
        RXS_FETCH   = 3'd1,
        RXS_CHECK   = 3'd2,
        RXS_WAIT    = 3'd3,
        RXS_SUSPEND = 3'd4,
        RXS_CLOSE   = 3'd5,
        RXS_FLUSH   = 3'd6,
        RXS_QUEUE   = 3'd7
    } rx_state_e;

endpackage

// File: rtl/dma_irq_cause_bank.sv
module dma_irq_cause_bank #(
    parameter int N = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ev,
    input  logic [N-1:0] clr,
    output logic [N-1:0] cause
);

    for (genvar k = 0; k < N; k++) begin : g_bit
        // a new event outranks a same-cycle clear
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cause[k] <= 1'b0;
            else if (ev[k])
                cause[k] <= 1'b1;
            else if (clr[k])
                cause[k] <= 1'b0;
        end
    end

endmodule

// File: rtl/dma_irq_ctrl_regs.sv
module dma_irq_ctrl_regs #(
    parameter int N = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_ctrl,
    input  logic         wr_poll,
    input  logic         wr_ien,
    input  logic [1:0]   ctrl_wdata,
    input  logic [N-1:0] ien_wdata,
    input  logic         ien_ais_wdata,
    input  logic         ien_nis_wdata,
    output logic         tx_run,
    output logic         rx_run,
    output logic         poll,
    output logic [N-1:0] ien_cause,
    output logic         ien_ais,
    output logic         ien_nis
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_run <= 1'b0;
            rx_run <= 1'b0;
        end else if (wr_ctrl) begin
            tx_run <= ctrl_wdata[0];
            rx_run <= ctrl_wdata[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            poll <= 1'b0;
        else
            poll <= wr_poll;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ien_cause <= '0;
            ien_ais   <= 1'b0;
            ien_nis   <= 1'b0;
        end else if (wr_ien) begin
            ien_cause <= ien_wdata;
            ien_ais   <= ien_ais_wdata;
            ien_nis   <= ien_nis_wdata;
        end
    end

endmodule

// File: rtl/dma_irq_csr.sv
module dma_irq_csr
    import dma_irq_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   csr_addr,
    input  logic                csr_wr,
    input  logic [CSR_W-1:0]    csr_wdata,
    output logic [CSR_W-1:0]    csr_rdata,
    input  logic [N_CAUSE-1:0]  ev_i,
    input  logic [ST_W-1:0]     tx_state_i,
    input  logic [ST_W-1:0]     rx_state_i,
    output logic                tx_run_o,
    output logic                rx_run_o,
    output logic                tx_poll_o,
    output logic                irq_o
);

    localparam int SEL_W = 2;

    csr_sel_e           sel;
    logic               hit;
    logic               wr_ctrl, wr_poll, wr_ien, wr_stat;
    logic [N_CAUSE-1:0] clr_vec;
    logic [N_CAUSE-1:0] cause_q;
    logic [N_CAUSE-1:0] ien_cause;
    logic               ien_ais, ien_nis;
    logic               ais_sum, nis_sum;
    logic               irq_q;

    assign sel = csr_sel_e'(csr_addr[SEL_W-1:0]);

    if (ADDR_W > SEL_W) begin : g_hi_dec
        assign hit = (csr_addr[ADDR_W-1:SEL_W] == '0);
    end else begin : g_no_hi
        assign hit = 1'b1;
    end

    // write strobe decode per register select
    always_comb begin
        wr_ctrl = 1'b0;
        wr_poll = 1'b0;
        wr_ien  = 1'b0;
        wr_stat = 1'b0;
        if (csr_wr && hit) begin
            unique case (sel)
                SEL_CTRL: wr_ctrl = 1'b1;
                SEL_POLL: wr_poll = 1'b1;
                SEL_IEN:  wr_ien  = 1'b1;
                SEL_STAT: wr_stat = 1'b1;
            endcase
        end
    end

    assign clr_vec = wr_stat ? csr_wdata[N_CAUSE-1:0] : '0;

    dma_irq_cause_bank #(.N(N_CAUSE)) u_causes (
        .clk   (clk),
        .rst_n (rst_n),
        .ev    (ev_i),
        .clr   (clr_vec),
        .cause (cause_q)
    );

    dma_irq_ctrl_regs #(.N(N_CAUSE)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_ctrl       (wr_ctrl),
        .wr_poll       (wr_poll),
        .wr_ien        (wr_ien),
        .ctrl_wdata    ({csr_wdata[CTRL_RX_BIT], csr_wdata[CTRL_TX_BIT]}),
        .ien_wdata     (csr_wdata[N_CAUSE-1:0]),
        .ien_ais_wdata (csr_wdata[AIS_BIT]),
        .ien_nis_wdata (csr_wdata[NIS_BIT]),
        .tx_run        (tx_run_o),
        .rx_run        (rx_run_o),
        .poll          (tx_poll_o),
        .ien_cause     (ien_cause),
        .ien_ais       (ien_ais),
        .ien_nis       (ien_nis)
    );

    // summaries come from enabled causes only
    assign ais_sum = |(cause_q & ien_cause & ABN_MASK);
    assign nis_sum = |(cause_q & ien_cause & NORM_MASK);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else
            irq_q <= (ais_sum & ien_ais) | (nis_sum & ien_nis);
    end

    assign irq_o = irq_q;

    // read path per register select
    always_comb begin
        csr_rdata = '0;
        if (hit) begin
            unique case (sel)
                SEL_CTRL: begin
                    csr_rdata[CTRL_TX_BIT] = tx_run_o;
                    csr_rdata[CTRL_RX_BIT] = rx_run_o;
                end
                SEL_POLL: ;
                SEL_IEN: begin
                    csr_rdata[N_CAUSE-1:0] = ien_cause;
                    csr_rdata[AIS_BIT]     = ien_ais;
                    csr_rdata[NIS_BIT]     = ien_nis;
                end
                SEL_STAT: begin
                    csr_rdata[N_CAUSE-1:0]              = cause_q;
                    csr_rdata[AIS_BIT]                  = ais_sum;
                    csr_rdata[NIS_BIT]                  = nis_sum;
                    csr_rdata[RX_ST_LSB +: ST_W]        = rx_state_i;
                    csr_rdata[TX_ST_LSB +: ST_W]        = tx_state_i;
                end
            endcase
        end
    end

endmodule

// File: rtl/dma_irq_csr_chk.sv
module dma_irq_csr_chk
    import dma_irq_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               csr_wr,
    input logic [ADDR_W-1:0]  csr_addr,
    input logic [N_CAUSE-1:0] ev_i,
    input logic [N_CAUSE-1:0] cause_q,
    input logic               ais_sum,
    input logic               nis_sum,
    input logic               ien_ais,
    input logic               ien_nis,
    input logic               tx_run_o,
    input logic               rx_run_o,
    input logic               tx_poll_o,
    input logic               irq_o
);

    logic wr_ctrl_c, wr_poll_c, wr_stat_c;
    assign wr_ctrl_c = csr_wr && (csr_addr == ADDR_W'(0));
    assign wr_poll_c = csr_wr && (csr_addr == ADDR_W'(1));
    assign wr_stat_c = csr_wr && (csr_addr == ADDR_W'(3));

    p_ctrl_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl_c |=> $stable({tx_run_o, rx_run_o}));

    p_poll_fire_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_poll_c |=> tx_poll_o);

    p_poll_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_poll_c |=> !tx_poll_o);

    p_event_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev_i) |=> ((cause_q & $past(ev_i)) == $past(ev_i)));

    p_cause_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|ev_i) && !wr_stat_c) |=> $stable(cause_q));

    p_irq_raise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((ais_sum && ien_ais) || (nis_sum && ien_nis)) |=> irq_o);

    p_irq_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ien_ais && !ien_nis) |=> !irq_o);

endmodule

bind dma_irq_csr dma_irq_csr_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .csr_wr    (csr_wr),
    .csr_addr  (csr_addr),
    .ev_i      (ev_i),
    .cause_q   (cause_q),
    .ais_sum   (ais_sum),
    .nis_sum   (nis_sum),
    .ien_ais   (ien_ais),
    .ien_nis   (ien_nis),
    .tx_run_o  (tx_run_o),
    .rx_run_o  (rx_run_o),
    .tx_poll_o (tx_poll_o),
    .irq_o     (irq_o)
);

// File: tb/test_dma_irq_csr.sv
module test_dma_irq_csr;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [AW-1:0] csr_addr = '0;
    logic        csr_wr = 1'b0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic [10:0] ev_i = '0;
    logic [2:0]  tx_state_i = '0;
    logic [2:0]  rx_state_i = '0;
    logic        tx_run_o, rx_run_o, tx_poll_o, irq_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_irq_csr #(.ADDR_W(AW)) i_dma_irq_csr (
        .clk        (clk),
        .rst_n      (rst_n),
        .csr_addr   (csr_addr),
        .csr_wr     (csr_wr),
        .csr_wdata  (csr_wdata),
        .csr_rdata  (csr_rdata),
        .ev_i       (ev_i),
        .tx_state_i (tx_state_i),
        .rx_state_i (rx_state_i),
        .tx_run_o   (tx_run_o),
        .rx_run_o   (rx_run_o),
        .tx_poll_o  (tx_poll_o),
        .irq_o      (irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        csr_wr = 1'b1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_wr = 1'b0; csr_wdata = '0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        csr_addr = a;
        #1;
        d = csr_rdata;
    endtask

    task automatic pulse(input logic [10:0] m);
        @(negedge clk);
        ev_i = m;
        @(negedge clk);
        ev_i = '0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        for (int a = 0; a < 4; a++) begin
            rd(AW'(a), d);
            check("R1 reg after reset", d, 32'h0);
        end
        check("R1 outputs after reset", {28'h0, tx_run_o, rx_run_o, tx_poll_o, irq_o}, 32'h0);
    endtask

    task automatic t_ctrl;
        logic [31:0] d;
        wr(0, 32'h1); rd(0, d);
        check("R2 tx start only", d, 32'h1);
        check("R2 run pins tx", {30'h0, rx_run_o, tx_run_o}, 32'h1);
        wr(0, 32'h2); rd(0, d);
        check("R2 rx start only", d, 32'h2);
        check("R2 run pins rx", {30'h0, rx_run_o, tx_run_o}, 32'h2);
        wr(0, 32'h3); rd(0, d);
        check("R2 both started", d, 32'h3);
        wr(0, 32'hFFFF_FFFC); rd(0, d);
        check("R2 reserved bits read 0", d, 32'h0);
    endtask

    task automatic t_poll;
        logic [31:0] d;
        wr(1, 32'h0);
        check("R3 poll strobe high", {31'h0, tx_poll_o}, 32'h1);
        @(negedge clk);
        check("R3 poll strobe one cycle", {31'h0, tx_poll_o}, 32'h0);
        rd(1, d);
        check("R3 poll reads 0", d, 32'h0);
    endtask

    task automatic t_masked;
        logic [31:0] d;
        wr(2, 32'h0);
        pulse(11'h7FF);
        rd(3, d);
        check("R4 R10 all causes latched, summaries 0", d, 32'h0000_07FF);
        @(negedge clk);
        check("R10 irq masked", {31'h0, irq_o}, 32'h0);
        @(negedge clk);
        rd(3, d);
        check("R4 causes held", d, 32'h0000_07FF);
        check("R10 irq still masked", {31'h0, irq_o}, 32'h0);
    endtask

    task automatic t_w1c;
        logic [31:0] d;
        wr(3, 32'h5); rd(3, d);
        check("R5 clear bits 0 and 2", d, 32'h0000_07FA);
        wr(3, 32'h0); rd(3, d);
        check("R5 zero write no effect", d, 32'h0000_07FA);
        wr(3, 32'hFFFE_0000); rd(3, d);
        check("R5 upper bits ignore writes", d, 32'h0000_07FA);
        wr(3, 32'h7FF); rd(3, d);
        check("R5 clear all", d, 32'h0);
    endtask

    task automatic t_state;
        logic [31:0] d;
        tx_state_i = 3'd6; rx_state_i = 3'd4;
        rd(3, d);
        check("R11 suspended codes", d, 32'h0068_0000);
        tx_state_i = 3'd3; rx_state_i = 3'd7;
        rd(3, d);
        check("R11 read and queue codes", d, 32'h003E_0000);
        tx_state_i = 3'd0; rx_state_i = 3'd0;
    endtask

    task automatic t_normal;
        logic [31:0] d;
        wr(2, 32'h0001_87FF); rd(2, d);
        check("R10 enable readback", d, 32'h0001_87FF);
        pulse(11'h001);
        rd(3, d);
        check("R8 normal summary set", d, 32'h0001_0001);
        check("R9 irq lags one cycle", {31'h0, irq_o}, 32'h0);
        @(negedge clk);
        check("R9 irq raised", {31'h0, irq_o}, 32'h1);
        wr(3, 32'h0001_0000); rd(3, d);
        check("R12 summary stays with cause set", d, 32'h0001_0001);
        wr(3, 32'h1); rd(3, d);
        check("R8 summary clears with cause", d, 32'h0);
        check("R9 irq falls one cycle late", {31'h0, irq_o}, 32'h1);
        @(negedge clk);
        check("R9 irq low", {31'h0, irq_o}, 32'h0);
    endtask

    task automatic t_abnormal;
        logic [31:0] d;
        wr(2, 32'h0000_8400);
        pulse(11'h100);
        rd(3, d);
        check("R7 unenabled cause no summary", d, 32'h0000_0100);
        @(negedge clk);
        check("R7 no irq from unenabled cause", {31'h0, irq_o}, 32'h0);
        pulse(11'h400);
        rd(3, d);
        check("R7 fatal bus sets summary", d, 32'h0000_8500);
        @(negedge clk);
        check("R9 abnormal irq", {31'h0, irq_o}, 32'h1);
        wr(3, 32'h500);
        wr(3, 32'h0000_8000); rd(3, d);
        check("R12 summary write with nothing set", d, 32'h0);
    endtask

    task automatic t_collide;
        logic [31:0] d;
        pulse(11'h008);
        @(negedge clk);
        csr_wr = 1'b1; csr_addr = 3; csr_wdata = 32'h8; ev_i = 11'h008;
        @(negedge clk);
        csr_wr = 1'b0; csr_wdata = '0; ev_i = '0;
        rd(3, d);
        check("R6 event wins over clear", d, 32'h0000_0008);
        wr(3, 32'h8); rd(3, d);
        check("R5 cleared afterwards", d, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctrl();
        t_poll();
        t_masked();
        t_w1c();
        t_state();
        t_normal();
        t_abnormal();
        t_collide();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule